// File: doc/BRIEF.md
# Fractional M/N Rate Enable Generator

This block turns a fast clock into a slower event rate that is a programmable fraction M/N of it. It does not make a new clock. It raises a one-cycle enable on its output, on average M times in every N input cycles, so that downstream logic on the same clock can advance only on enabled cycles. An accumulator adds M on every cycle. When the running sum reaches N, the block emits a pulse and subtracts N from the sum. The long-run ratio is therefore exact, and the pulses are spread as evenly as the clock grid allows.

M and N sit in two fields of one 32-bit control word. The word is written and read back over a plain register port. The offsets and widths of the two fields are elaboration parameters. Further parameters select three options: a minus-one field encoding, byte-swapped access on the port, and a divide-by-2^SCALE stage after the fractional stage. The last one reaches ratios far below 1/(2^NWIDTH−1). A zero effective M or N makes the block pass every cycle through. A new ratio is adopted only at a pulse boundary.

Top module: `frac_rate_div`

## Requirements
- R1: When the accumulator starts at zero right after a pulse, and the effective ratio satisfies 0 < M < N, cycle t after that pulse carries a fractional pulse exactly when floor(t·M/N) > floor((t−1)·M/N). Any N consecutive cycles measured from that point therefore hold exactly M pulses.
- R2: M is read from control bits [MSHIFT+MWIDTH−1 : MSHIFT] and N from bits [NSHIFT+NWIDTH−1 : NSHIFT].
- R3: With ZERO_BASED set, the effective M and N are each one more than their stored field values.
- R4: If the effective M or the effective N is zero, the fractional stage pulses on every cycle.
- R5: If the effective M is greater than or equal to a nonzero effective N, the fractional stage pulses on every cycle.
- R6: A write replaces only the M and N field bits. Every other control bit keeps its reset value CTRL_INIT.
- R7: rd_data always shows the current control word, including the bits outside the fields.
- R8: With BYTE_SWAP set, the port byte order is reversed in both directions. Port byte 0 (bits 7:0) maps to control bits 31:24, and so on.
- R9: A ratio written to the register is adopted on the cycle of the next fractional pulse. If the adopted ratio differs from the old one, the accumulator restarts from zero.
- R10: With SCALE > 0, div_en rises once for every 2^SCALE fractional pulses. It is never high on two consecutive cycles.
- R11: Synchronous reset loads CTRL_INIT into the control word and clears the accumulator, the adopted ratio and the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock whose rate is divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data, in port byte order |
| rd_data | output | 32 | Control word readback, in port byte order |
| div_en | output | 1 | One-cycle rate enable after the prescaler |

## Verification
The assertions assume that reset is held across at least one rising edge before the first check. They also assume that the control word changes only through wr_en. Under those conditions they can hold the accumulator below the adopted N and the adopted ratio steady between pulses. The stimulus keeps to these conditions. After each write it ignores the cycle of the write edge itself and waits for the next pulse before it measures anything. Every measured window therefore begins at a known adoption point with a cleared accumulator. Successive ratios always differ, so each measurement starts from a real ratio change.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    typedef enum logic [1:0] {
        RM_PASS,
        RM_SAT,
        RM_FRAC
    } ratio_mode_e;

    function automatic logic [31:0] bswap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] field_mask(input int unsigned sh, input int unsigned w);
        return ((32'd1 << w) - 32'd1) << sh;
    endfunction

endpackage

// File: rtl/frac_ctrl_reg.sv
module frac_ctrl_reg
    import frac_div_pkg::*;
#(
    parameter int unsigned MSHIFT     = 0,
    parameter int unsigned MWIDTH     = 8,
    parameter int unsigned NSHIFT     = 16,
    parameter int unsigned NWIDTH     = 8,
    parameter bit          ZERO_BASED = 1'b0,
    parameter bit          BYTE_SWAP  = 1'b0,
    parameter logic [31:0] CTRL_INIT  = 32'h0,
    parameter int unsigned CW         = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    output logic [31:0]   rd_data,
    output logic [CW-1:0] m_cfg,
    output logic [CW-1:0] n_cfg
);

    localparam logic [31:0] FMASK = field_mask(MSHIFT, MWIDTH) | field_mask(NSHIFT, NWIDTH);

    logic [31:0] ctrl;
    logic [31:0] wr_int;

    generate
        if (BYTE_SWAP) begin : g_swap
            assign wr_int  = bswap32(wr_data);
            assign rd_data = bswap32(ctrl);
        end else begin : g_native
            assign wr_int  = wr_data;
            assign rd_data = ctrl;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_INIT;
        end else if (wr_en) begin
            ctrl <= (ctrl & ~FMASK) | (wr_int & FMASK);
        end
    end

    assign m_cfg = CW'(ctrl[MSHIFT +: MWIDTH]) + CW'(ZERO_BASED);
    assign n_cfg = CW'(ctrl[NSHIFT +: NWIDTH]) + CW'(ZERO_BASED);

    AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((ctrl & ~FMASK) == (CTRL_INIT & ~FMASK))); // R6

endmodule

// File: rtl/frac_accum.sv
module frac_accum
    import frac_div_pkg::*;
#(
    parameter int unsigned CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] m_cfg,
    input  logic [CW-1:0] n_cfg,
    output logic          frac_en
);

    logic [CW-1:0] acc;
    logic [CW-1:0] acc_nxt;
    logic [CW-1:0] m_act;
    logic [CW-1:0] n_act;
    logic [CW:0]   sum;
    logic          hit;
    logic          cfg_new;
    ratio_mode_e   mode;

    always_comb begin
        sum = {1'b0, acc} + {1'b0, m_act};
        if (m_act == '0 || n_act == '0) begin
            mode = RM_PASS;
        end else if (m_act >= n_act) begin
            mode = RM_SAT;
        end else begin
            mode = RM_FRAC;
        end
        hit     = 1'b1;
        acc_nxt = '0;
        case (mode)
            RM_FRAC: begin
                if (sum >= {1'b0, n_act}) begin
                    acc_nxt = CW'(sum - {1'b0, n_act});
                end else begin
                    hit     = 1'b0;
                    acc_nxt = sum[CW-1:0];
                end
            end
            default: begin
                hit     = 1'b1;
                acc_nxt = '0;
            end
        endcase
        cfg_new = (m_cfg != m_act) || (n_cfg != n_act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            m_act   <= '0;
            n_act   <= '0;
            frac_en <= 1'b0;
        end else begin
            frac_en <= hit;
            if (hit) begin
                m_act <= m_cfg;
                n_act <= n_cfg;
                acc   <= cfg_new ? '0 : acc_nxt;
            end else begin
                acc   <= acc_nxt;
            end
        end
    end

    AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (rst)
        (n_act != '0) |-> (acc < n_act)); // R1

    AST_PASS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (m_act == '0 || n_act == '0) |=> frac_en); // R4

    AST_SAT_FULL: assert property (@(posedge clk) disable iff (rst)
        (n_act != '0 && m_act >= n_act) |=> frac_en); // R5

    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        !frac_en |-> ($stable(m_act) && $stable(n_act))); // R9

endmodule

// File: rtl/frac_prescale.sv
module frac_prescale
    import frac_div_pkg::*;
#(
    parameter int unsigned SCALE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frac_en,
    output logic div_en
);

    logic [SCALE-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (frac_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign div_en = frac_en && (cnt == '1);

    AST_PRE_SPACED: assert property (@(posedge clk) disable iff (rst)
        div_en |=> !div_en); // R10

endmodule

// File: rtl/frac_rate_div.sv
module frac_rate_div
    import frac_div_pkg::*;
#(
    parameter int unsigned MSHIFT     = 0,
    parameter int unsigned MWIDTH     = 8,
    parameter int unsigned NSHIFT     = 16,
    parameter int unsigned NWIDTH     = 8,
    parameter bit          ZERO_BASED = 1'b0,
    parameter bit          BYTE_SWAP  = 1'b0,
    parameter int unsigned SCALE      = 0,
    parameter logic [31:0] CTRL_INIT  = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        div_en
);

    localparam int unsigned CW = ((MWIDTH > NWIDTH) ? MWIDTH : NWIDTH) + 1;

    logic [CW-1:0] m_cfg;
    logic [CW-1:0] n_cfg;
    logic          frac_en;

    frac_ctrl_reg #(
        .MSHIFT    (MSHIFT),
        .MWIDTH    (MWIDTH),
        .NSHIFT    (NSHIFT),
        .NWIDTH    (NWIDTH),
        .ZERO_BASED(ZERO_BASED),
        .BYTE_SWAP (BYTE_SWAP),
        .CTRL_INIT (CTRL_INIT),
        .CW        (CW)
    ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .m_cfg  (m_cfg),
        .n_cfg  (n_cfg)
    );

    frac_accum #(
        .CW(CW)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .m_cfg  (m_cfg),
        .n_cfg  (n_cfg),
        .frac_en(frac_en)
    );

    generate
        if (SCALE == 0) begin : g_direct
            assign div_en = frac_en;
        end else begin : g_scaled
            frac_prescale #(
                .SCALE(SCALE)
            ) u_pre (
                .clk    (clk),
                .rst    (rst),
                .frac_en(frac_en),
                .div_en (div_en)
            );
        end
    endgenerate

endmodule

// File: tb/sim_frac_rate_div.sv
`timescale 1ns/1ps
module sim_frac_rate_div;

    localparam logic [31:0] INIT0 = 32'h5A5A_5A5A;
    localparam logic [31:0] MASK0 = (32'h7 << 4) | (32'h7 << 12);
    localparam logic [31:0] INIT1 = 32'h1234_5678;
    localparam logic [31:0] MASK1 = 32'h7 | (32'h7 << 8);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic        wr_en0 = 1'b0, wr_en1 = 1'b0;
    logic [31:0] wr_data0 = '0, wr_data1 = '0;
    logic [31:0] rd_data0, rd_data1;
    logic        div0, div1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frac_rate_div #(
        .MSHIFT(4), .MWIDTH(3), .NSHIFT(12), .NWIDTH(3),
        .ZERO_BASED(1'b0), .BYTE_SWAP(1'b0), .SCALE(0), .CTRL_INIT(INIT0)
    ) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en0), .wr_data(wr_data0),
        .rd_data(rd_data0), .div_en(div0)
    );

    frac_rate_div #(
        .MSHIFT(0), .MWIDTH(3), .NSHIFT(8), .NWIDTH(3),
        .ZERO_BASED(1'b1), .BYTE_SWAP(1'b1), .SCALE(2), .CTRL_INIT(INIT1)
    ) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en1), .wr_data(wr_data1),
        .rd_data(rd_data1), .div_en(div1)
    );

    function automatic logic [31:0] swap_bytes(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write0(input logic [31:0] d);
        @(negedge clk);
        wr_en0 = 1'b1; wr_data0 = d;
        @(negedge clk);
        wr_en0 = 1'b0;
    endtask

    task automatic write1(input logic [31:0] d);
        @(negedge clk);
        wr_en1 = 1'b1; wr_data1 = d;
        @(negedge clk);
        wr_en1 = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int fm1[5] = '{0, 2, 6, 0, 4};
        int fn1[5] = '{0, 7, 2, 7, 6};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset contents, R8: swapped view on u1
        chk(rd_data0 == INIT0, "R11 reset word u0", rd_data0, INIT0);
        chk(rd_data1 == swap_bytes(INIT1), "R11 R8 reset word u1", rd_data1, swap_bytes(INIT1));

        // u0: sweep every M and N field value, direct encoding
        for (int m = 0; m < 8; m++) begin
            for (int n = 0; n < 8; n++) begin
                logic [31:0] wd, ex;
                int len, cnt;
                bit full;
                wd = (~INIT0 & ~MASK0) | (32'(m) << 4) | (32'(n) << 12);
                ex = (INIT0 & ~MASK0) | (wd & MASK0);
                write0(wd);
                chk(rd_data0 == ex, "R6 R7 readback u0", rd_data0, ex);
                @(negedge clk);
                while (!div0) @(negedge clk);
                full = (m == 0) || (n == 0) || (m >= n);
                len  = (n == 0) ? 4 : 2 * n;
                cnt  = 0;
                for (int t = 1; t <= len; t++) begin
                    bit e;
                    @(negedge clk);
                    e = full ? 1'b1 : (((t * m) / n) != (((t - 1) * m) / n));
                    if (div0) cnt++;
                    if (m == 0 || n == 0)
                        chk(div0 == e, "R4 pass-through", div0, e);
                    else if (m >= n)
                        chk(div0 == e, "R5 saturation", div0, e);
                    else
                        chk(div0 == e, "R1 R2 R9 pulse pattern", div0, e);
                end
                if (!full) chk(cnt == 2 * m, "R1 pulse count", cnt, 2 * m);
            end
        end

        // u1: minus-one encoding, byte swap, divide-by-4 prescaler
        for (int i = 0; i < 5; i++) begin
            logic [31:0] wint, ex;
            int me, ne, cnt, expc;
            bit prev;
            wint = (~INIT1 & ~MASK1) | 32'(fm1[i]) | (32'(fn1[i]) << 8);
            ex   = (INIT1 & ~MASK1) | (wint & MASK1);
            write1(swap_bytes(wint));
            chk(rd_data1 == swap_bytes(ex), "R8 R6 swapped readback u1", rd_data1, swap_bytes(ex));
            me = fm1[i] + 1;
            ne = fn1[i] + 1;
            expc = (me < ne) ? me : ne;
            @(negedge clk);
            while (!div1) @(negedge clk);
            cnt  = 0;
            prev = 1'b1;
            for (int t = 1; t <= 4 * ne; t++) begin
                @(negedge clk);
                if (div1) cnt++;
                if (prev && div1) chk(1'b0, "R10 adjacent pulses", 1, 0);
                prev = div1;
            end
            chk(cnt == expc, "R3 R10 scaled count", cnt, expc);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule